// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Controller

This block watches eight general-purpose input pin positions. It raises one shared interrupt request when an enabled pin makes a transition in the direction programmed for that pin. Two write-only control bytes set the behaviour of each pin: an enable mask and a direction mask. Both are loaded over a small write-only register bus. Only pin positions 0, 1, 2 and 7 exist. Positions 3 to 6 are reserved and never take part.

Each pin passes through a two-stage synchronizer. After that stage, the current level is compared with the level held one cycle earlier. A qualifying transition on any pin sets a sticky pending flag, and that flag drives the request line. The interrupt controller downstream sees only this line and clears it with a one-cycle acknowledge pulse.

Top module: `pin_edge_irq`

## Requirements
- R1: While reset is asserted and after it is released, `irq_o` is 0, every enable bit is 0 and every direction bit is 0 (falling edge), so pin transitions made after reset raise no request.
- R2: Enable bit n set to 1 lets pin n raise the request. Set to 0, pin n cannot raise it.
- R3: Direction bit n set to 0 selects a falling transition (1 to 0) on pin n. Set to 1, it selects a rising transition (0 to 1).
- R4: Only bit positions 0, 1, 2 and 7 are implemented. Writes to bits 3 to 6 of either control byte are ignored, and pins 3 to 6 never raise the request.
- R5: The enable byte is written at address 0x31 and the direction byte at address 0x32. Writes to any other address change nothing.
- R6: All implemented pins share the single output `irq_o`. A qualifying transition on any one of them raises it.
- R7: Once raised, `irq_o` stays at 1 until `ack_i` is high on a rising clock edge. After that edge it reads 0.
- R8: A qualifying transition detected in the same cycle as `ack_i` leaves `irq_o` at 1.
- R9: `irq_o` first reads 1 after the third rising clock edge that follows a pin change. It still reads 0 after the second.
- R10: Writing a direction bit while the pin holds a steady level raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | 8 | Asynchronous pin levels, bit n is pin n |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| ack_i | input | 1 | Acknowledge pulse that clears the pending request |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The stimulus table pairs enable and direction settings with pin transitions. It covers rising against falling edges on matching and mismatched directions, enabled against disabled pins, each implemented position, reserved positions, and mixed per-pin directions in which only some pins change in the selected direction. A mismatched-direction case tells whether the direction bit is applied per pin. A reserved-position case tells whether masking happens at write time. Directed tests then cover the exact latency, an acknowledge that coincides with a fresh edge, direction changes over steady levels, writes to neighbouring addresses, and the state left after a mid-run reset.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int PIN_W  = 8;
  localparam int ADDR_W = 8;
  typedef logic [PIN_W-1:0]  pin_vec_t;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam pin_vec_t IMPL_MASK_DEF = 8'h87;
  localparam addr_t    ENA_ADDR_DEF  = 8'h31;
  localparam addr_t    DIR_ADDR_DEF  = 8'h32;
endpackage

// File: rtl/pin_irq_rst_sync.sv
module pin_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs #(
  parameter int              W         = 8,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ENA_ADDR  = 8'h31,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h32,
  parameter logic [W-1:0]    IMPL_MASK = 8'h87
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      ena_q,
  output logic [W-1:0]      dir_q
);
  logic         ena_we;
  logic         dir_we;
  logic [W-1:0] wr_masked;

  always_comb begin
    ena_we    = wr_en && (wr_addr == ENA_ADDR);
    dir_we    = wr_en && (wr_addr == DIR_ADDR);
    wr_masked = wr_data & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena_q <= '0;
    else if (ena_we) ena_q <= wr_masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_we) dir_q <= wr_masked;
  end
endmodule

// File: rtl/pin_irq_edge.sv
module pin_irq_edge #(
  parameter int           W         = 8,
  parameter logic [W-1:0] IMPL_MASK = 8'h87
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] ena,
  input  logic [W-1:0] dir,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (IMPL_MASK[i]) begin : g_impl
      logic rise;
      logic fall;
      always_comb begin
        rise   = lvl[i] & ~prev_q[i];
        fall   = ~lvl[i] & prev_q[i];
        hit[i] = ena[i] & (dir[i] ? rise : fall);
      end
    end else begin : g_rsvd
      assign hit[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pin_irq_pkg::*;
#(
  parameter int       W         = PIN_W,
  parameter int       AW        = ADDR_W,
  parameter int       SYNC_STG  = 2,
  parameter logic [W-1:0]  IMPL_MASK = IMPL_MASK_DEF,
  parameter logic [AW-1:0] ENA_ADDR  = ENA_ADDR_DEF,
  parameter logic [AW-1:0] DIR_ADDR  = DIR_ADDR_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pins_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          ack_i,
  output logic          irq_o
);
  logic         rst_sync_n;
  logic [W-1:0] lvl_sync;
  logic [W-1:0] ena_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] hit_vec;
  logic         hit_any;
  logic         pend_q;
  logic         pend_d;

  pin_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pin_irq_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(pins_i), .dout(lvl_sync)
  );

  pin_irq_regs #(
    .W(W), .ADDR_W(AW), .ENA_ADDR(ENA_ADDR), .DIR_ADDR(DIR_ADDR),
    .IMPL_MASK(IMPL_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .ena_q(ena_q), .dir_q(dir_q)
  );

  pin_irq_edge #(.W(W), .IMPL_MASK(IMPL_MASK)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .lvl(lvl_sync), .ena(ena_q),
    .dir(dir_q), .hit(hit_vec)
  );

  always_comb begin
    hit_any = |hit_vec;
    pend_d  = hit_any | (pend_q & ~ack_i);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pend_q <= 1'b0;
    else             pend_q <= pend_d;
  end

  assign irq_o = pend_q;
endmodule

// File: rtl/pin_edge_irq_chk.sv
module pin_edge_irq_chk #(
  parameter int           W         = 8,
  parameter logic [W-1:0] IMPL_MASK = 8'h87
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ack_i,
  input logic         irq_o,
  input logic         hit_any,
  input logic [W-1:0] hit_vec,
  input logic [W-1:0] ena_q
);
  p_hit_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |=> irq_o);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> irq_o);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !hit_any) |=> !irq_o);

  p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(hit_any));

  p_ack_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && hit_any) |=> irq_o);

  p_rsvd_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_vec & ~IMPL_MASK) == '0) && ((ena_q & ~IMPL_MASK) == '0));

  p_hit_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~ena_q) == '0);
endmodule

bind pin_edge_irq pin_edge_irq_chk #(.W(W), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ack_i(ack_i), .irq_o(irq_o),
  .hit_any(hit_any), .hit_vec(hit_vec), .ena_q(ena_q)
);

// File: tb/pin_edge_irq_test.sv
module pin_edge_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       ack = 1'b0;
  logic       irq;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  pin_edge_irq uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ack_i(ack), .irq_o(irq)
  );

  // {enable, direction, level before, level after, expected irq}
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {8'h01, 8'h00, 8'h01, 8'h00, 1'b1},  // R3 falling selected, falls
    {8'h01, 8'h00, 8'h00, 8'h01, 1'b0},  // R3 falling selected, rises
    {8'h01, 8'h01, 8'h00, 8'h01, 1'b1},  // R3 rising selected, rises
    {8'h01, 8'h01, 8'h01, 8'h00, 1'b0},  // R3 rising selected, falls
    {8'h02, 8'h00, 8'h01, 8'h00, 1'b0},  // R2 pin0 disabled
    {8'h80, 8'h80, 8'h00, 8'h80, 1'b1},  // R6 pin7
    {8'h04, 8'h00, 8'h04, 8'h00, 1'b1},  // R6 pin2
    {8'h78, 8'h78, 8'h00, 8'h78, 1'b0},  // R4 reserved pins
    {8'h87, 8'h05, 8'h82, 8'h00, 1'b1},  // R3 mixed, pin1 falls
    {8'h87, 8'h05, 8'h00, 8'h82, 1'b0},  // R3 mixed, wrong directions
    {8'h00, 8'hFF, 8'h00, 8'hFF, 1'b0},  // R2 all disabled
    {8'h83, 8'h00, 8'hFF, 8'h7F, 1'b1}   // R6 pin7 falls among others
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pins = 8'h00;
    cyc(3);
    check("R1 reset asserted", irq, 1'b0);
    rst_n = 1'b1;
    cyc(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 after reset", irq, 1'b0);

    // R1: defaults disable every pin
    pins = 8'h87; cyc(5);
    pins = 8'h00; cyc(5);
    check("R1 disabled after reset", irq, 1'b0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      wr(8'h31, VEC[i][32:25]);
      wr(8'h32, VEC[i][24:17]);
      pins = VEC[i][16:9];
      cyc(5);
      do_ack();
      cyc(1);
      check("R7 cleared before vector", irq, 1'b0);
      pins = VEC[i][8:1];
      cyc(5);
      check($sformatf("R2/R3/R4/R6 vector %0d", i), irq, VEC[i][0]);
    end

    // R9: latency
    wr(8'h31, 8'h01); wr(8'h32, 8'h01);
    pins = 8'h00; cyc(5); do_ack(); cyc(1);
    pins = 8'h01;
    cyc(2);
    check("R9 not yet after two edges", irq, 1'b0);
    cyc(1);
    check("R9 set after third edge", irq, 1'b1);
    // R7: holds with no ack
    cyc(6);
    check("R7 sticky", irq, 1'b1);

    // R8: ack in the same cycle as a fresh edge
    wr(8'h32, 8'h00);
    check("R10 no clear from write", irq, 1'b1);
    pins = 8'h00;
    cyc(2);
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
    check("R8 edge with ack keeps irq", irq, 1'b1);
    do_ack();
    check("R7 ack clears", irq, 1'b0);

    // R10: direction change over steady levels
    wr(8'h31, 8'h87);
    pins = 8'h87; cyc(5); do_ack();
    wr(8'h32, 8'h87); cyc(4);
    check("R10 dir 0->1 pins high", irq, 1'b0);
    wr(8'h32, 8'h00); cyc(4);
    check("R10 dir 1->0 pins high", irq, 1'b0);
    pins = 8'h00; cyc(5); do_ack();
    wr(8'h32, 8'h87); cyc(4);
    check("R10 dir 0->1 pins low", irq, 1'b0);

    // R5: neighbouring addresses ignored
    do_reset();
    wr(8'h30, 8'hFF); wr(8'h33, 8'hFF);
    pins = 8'h01; cyc(5);
    pins = 8'h00; cyc(5);
    check("R5 other address no enable", irq, 1'b0);
    wr(8'h31, 8'h01);
    pins = 8'h01; cyc(5);
    pins = 8'h00; cyc(5);
    check("R5 enable address works", irq, 1'b1);
    do_ack();
    wr(8'h30, 8'hFF); wr(8'h33, 8'h00);
    pins = 8'h01; cyc(5);
    check("R5 other address no direction", irq, 1'b0);

    // R4: reserved bits written in both bytes
    wr(8'h31, 8'h78); wr(8'h32, 8'h78);
    pins = 8'h79; cyc(5);
    pins = 8'h00; cyc(5);
    check("R4 reserved ignored, pin0 cleared", irq, 1'b0);

    // R1: mid-run reset clears enable and direction
    wr(8'h31, 8'h87); wr(8'h32, 8'h87);
    do_reset();
    pins = 8'h87; cyc(5);
    pins = 8'h00; cyc(5);
    check("R1 registers cleared by reset", irq, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule